// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Slave

This block is the command side of a serial EEPROM slave that uses a select line, a serial clock, a data-in line and a data-out line. All four lines are sampled on a fast system clock. It keeps a word array whose size is set by parameters. While the select line is high, it looks for a start bit, an opcode and an address. It then runs one of these commands: read a word, write a word, clear a word, clear every word, fill every word with one value, or switch write protection on or off.

Every command that changes the array is gated by a write-enable latch. Such a command runs only if the select line drops in a narrow slot: after the last serial bit has been sampled and before the next serial clock rise. When it runs, a self-timed busy cycle of a fixed number of system clocks starts. This cycle needs no serial clock. When the select line is raised during or after the cycle, the data-out line reports the status. The serial pins carry no stream, so they are plain wires with no valid/ready handshake and no back-pressure. The host paces every transfer with the serial clock. The system reset stands in for power-up.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset every word reads as all ones and the write-enable latch is clear. A read (start 1, opcode bits 1 then 0, address MSB first) returns the word MSB first on `do_o`. The first bit is valid after the last address bit is sampled, and each further `sk` rise advances one bit. Reads work whether the latch is set or clear.
- R2: While the write-enable latch is clear, write, erase, erase-all and write-all frames change nothing and start no busy cycle.
- R3: A write (opcode 0 then 1, address, then DATA_W data bits MSB first) stores the data word at the address once its busy cycle ends.
- R4: An erase (opcode 1 then 1, address) sets the addressed word to all ones and leaves the other words unchanged.
- R5: Opcode 00 with top address bits 01, followed by a data word, writes that word into every location.
- R6: Opcode 00 with top address bits 10 sets every location to all ones. Opcode 00 with top bits 11 sets the latch.
- R7: A modifying command starts only when `cs` falls after its last bit and before the next `sk` rise. If `cs` falls earlier, or if an extra `sk` rise comes first, the command is discarded.
- R8: `do_oe` equals `cs`. When no read is shifting out, `do_o` is 0 while the busy cycle runs and 1 otherwise. The busy cycle lasts BUSY_CYCLES system clocks.
- R9: A complete command frame received while the busy cycle runs is ignored.
- R10: Opcode 00 with top address bits 00 clears the latch. Later modifying commands are then ignored until it is set again.
- R11: While `cs` is high and no frame has started, zeros sampled on `di` are skipped. The frame starts at the first 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial lines |
| rst_n | input | 1 | Active-low asynchronous reset, stands in for power-up |
| cs | input | 1 | Select line, active high |
| sk | input | 1 | Serial clock; `di` is sampled on its rising edge |
| di | input | 1 | Serial command, address and data input |
| do_o | output | 1 | Serial read data, or busy(0)/ready(1) status |
| do_oe | output | 1 | Drive enable for `do_o`; low means high impedance |

## Verification
The bench aims at the select-drop window from both sides. It drops `cs` before the last data bit, and in another frame it sends one extra `sk` rise before the drop. A design that ignores the window would program the word in both cases, and a later read would show the new value instead of all ones. It sends a full write frame while an earlier write is still busy. A design that accepts commands while busy would corrupt a second address. It also issues modifying frames with the latch clear, both after reset and after a disable command, and expects no busy status and no change. Leading zeros before the start bit and status polling during the busy cycle are checked as well. A design that miscounts the busy length or reports the status with the wrong polarity would fail the polling checks.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [1:0] {
    OP_WRITE,
    OP_ERASE,
    OP_ERASE_ALL,
    OP_WRITE_ALL
  } mw_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_ARMED,
    ST_READ,
    ST_DRAIN
  } mw_state_e;

endpackage

// File: rtl/mw_cmd_decoder.sv
module mw_cmd_decoder
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              sk,
  input  logic              di,
  input  logic              busy,
  output logic              exec_valid,
  output mw_op_e            exec_op,
  output logic [ADDR_W-1:0] exec_addr,
  output logic [DATA_W-1:0] exec_data,
  output logic              wel_set,
  output logic              wel_clr,
  output logic              in_read,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              dec_idle
);

  localparam int MAXW  = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CNT_W = $clog2(MAXW) + 1;

  mw_state_e         state;
  logic              sk_q, cs_q;
  logic [1:0]        opc;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt;
  logic              sk_rise;
  logic [ADDR_W-1:0] addr_next;

  assign sk_rise   = sk & ~sk_q;
  assign addr_next = {addr_q[ADDR_W-2:0], di};
  assign in_read   = (state == ST_READ);
  assign dec_idle  = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      sk_q       <= 1'b0;
      cs_q       <= 1'b0;
      opc        <= '0;
      addr_q     <= '0;
      cnt        <= '0;
      exec_valid <= 1'b0;
      exec_op    <= OP_WRITE;
      exec_addr  <= '0;
      exec_data  <= '0;
      wel_set    <= 1'b0;
      wel_clr    <= 1'b0;
      rd_addr    <= '0;
      rd_idx     <= '0;
    end else begin
      sk_q       <= sk;
      cs_q       <= cs;
      exec_valid <= 1'b0;
      wel_set    <= 1'b0;
      wel_clr    <= 1'b0;
      if (!cs) begin
        // the drop of the select line fires an armed command, aborts any other frame
        if (cs_q && state == ST_ARMED) exec_valid <= 1'b1;
        state <= ST_IDLE;
        cnt   <= '0;
      end else if (sk_rise) begin
        unique case (state)
          ST_IDLE: begin
            if (di && !busy) begin
              state <= ST_OPC;
              cnt   <= '0;
            end
          end
          ST_OPC: begin
            opc <= {opc[0], di};
            if (cnt == CNT_W'(1)) begin
              state <= ST_ADDR;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ADDR: begin
            addr_q <= addr_next;
            cnt    <= cnt + 1'b1;
            if (cnt == CNT_W'(ADDR_W - 1)) begin
              exec_addr <= addr_next;
              cnt       <= '0;
              unique case (opc)
                2'b10: begin
                  state   <= ST_READ;
                  rd_addr <= addr_next;
                  rd_idx  <= '0;
                end
                2'b01: begin
                  state   <= ST_DATA;
                  exec_op <= OP_WRITE;
                end
                2'b11: begin
                  state   <= ST_ARMED;
                  exec_op <= OP_ERASE;
                end
                default: begin
                  unique case (addr_next[ADDR_W-1 -: 2])
                    2'b11: begin
                      wel_set <= 1'b1;
                      state   <= ST_DRAIN;
                    end
                    2'b00: begin
                      wel_clr <= 1'b1;
                      state   <= ST_DRAIN;
                    end
                    2'b10: begin
                      state   <= ST_ARMED;
                      exec_op <= OP_ERASE_ALL;
                    end
                    default: begin
                      state   <= ST_DATA;
                      exec_op <= OP_WRITE_ALL;
                    end
                  endcase
                end
              endcase
            end
          end
          ST_DATA: begin
            exec_data <= {exec_data[DATA_W-2:0], di};
            cnt       <= cnt + 1'b1;
            if (cnt == CNT_W'(DATA_W - 1)) state <= ST_ARMED;
          end
          ST_ARMED: state <= ST_DRAIN;  // an extra clock edge closes the window
          ST_READ: begin
            if (rd_idx != IDX_W'(DATA_W)) rd_idx <= rd_idx + 1'b1;
          end
          default: state <= ST_DRAIN;
        endcase
      end
    end
  end

endmodule

// File: rtl/mw_busy_timer.sv
module mw_busy_timer #(
  parameter int CYCLES = 64,
  parameter int CYC_W  = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  logic [CYC_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      left <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          left <= CYC_W'(CYCLES - 1);
        end
      end else if (left == '0) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        left <= left - 1'b1;
      end
    end
  end

endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_one,
  input  logic              wr_all,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_all || (wr_one && wr_addr == ADDR_W'(i))) mem[i] <= wr_data;
      end
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int BUSY_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_o,
  output logic do_oe
);

  localparam int IDX_W = $clog2(DATA_W + 1);

  logic              exec_valid, wel_set, wel_clr, in_read, dec_idle;
  mw_op_e            exec_op, pend_op;
  logic [ADDR_W-1:0] exec_addr, pend_addr, rd_addr;
  logic [DATA_W-1:0] exec_data, pend_data, rd_data, rd_word, wr_data;
  logic [IDX_W-1:0]  rd_idx;
  logic              wel, busy, done, start;
  logic              wr_one, wr_all;

  mw_cmd_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .busy(busy),
    .exec_valid(exec_valid), .exec_op(exec_op), .exec_addr(exec_addr),
    .exec_data(exec_data), .wel_set(wel_set), .wel_clr(wel_clr),
    .in_read(in_read), .rd_addr(rd_addr), .rd_idx(rd_idx), .dec_idle(dec_idle)
  );

  assign start = exec_valid & wel & ~busy;

  mw_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel       <= 1'b0;
      pend_op   <= OP_WRITE;
      pend_addr <= '0;
      pend_data <= '0;
    end else begin
      if (wel_set) wel <= 1'b1;
      else if (wel_clr) wel <= 1'b0;
      if (start) begin
        pend_op   <= exec_op;
        pend_addr <= exec_addr;
        pend_data <= exec_data;
      end
    end
  end

  // the array is committed when the self-timed cycle ends
  assign wr_one  = done & (pend_op == OP_WRITE || pend_op == OP_ERASE);
  assign wr_all  = done & (pend_op == OP_WRITE_ALL || pend_op == OP_ERASE_ALL);
  assign wr_data = (pend_op == OP_ERASE || pend_op == OP_ERASE_ALL) ? '1 : pend_data;

  mw_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_one(wr_one), .wr_all(wr_all),
    .wr_addr(pend_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign rd_word = rd_data << rd_idx;
  assign do_o    = in_read ? rd_word[DATA_W-1] : ~busy;
  assign do_oe   = cs;

endmodule

// File: rtl/mw_eeprom_checker.sv
module mw_eeprom_checker #(
  parameter int BUSY_CYCLES = 64,
  parameter int LEN_W       = $clog2(BUSY_CYCLES + 2)
) (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic do_o,
  input logic busy,
  input logic wel,
  input logic dec_idle,
  input logic in_read
);

  logic [LEN_W-1:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= '0;
    else if (!busy) busy_len <= '0;
    else if (busy_len != '1) busy_len <= busy_len + 1'b1;
  end

  // R2: a self-timed cycle only begins with the latch set
  assert_start_needs_wel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wel);

  // R7: a cycle begins only after the select line has dropped
  assert_start_after_cs_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !cs);

  // R8: status polarity while busy
  assert_busy_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && busy && !in_read) |-> !do_o);

  // R8: cycle length is bounded by the parameter
  assert_busy_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_len <= LEN_W'(BUSY_CYCLES));

  // R9: no frame is taken in while busy
  assert_ignore_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> dec_idle);

endmodule

bind mw_eeprom_slave mw_eeprom_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .do_o(do_o), .busy(busy),
  .wel(wel), .dec_idle(dec_idle), .in_read(in_read)
);

// File: tb/test_mw_eeprom_slave.sv
module test_mw_eeprom_slave;

  localparam int AW   = 4;
  localparam int DW   = 8;
  localparam int BUSY = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_o, do_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] act_q[$];
  string         tag_q[$];

  always #2.5 clk = ~clk;

  mw_eeprom_slave #(.ADDR_W(AW), .DATA_W(DW), .BUSY_CYCLES(BUSY)) i_mw_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .do_o(do_o), .do_oe(do_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b);
    @(negedge clk) di = b;
    repeat (3) @(negedge clk);
    sk = 1'b1;
    repeat (4) @(negedge clk);
    sk = 1'b0;
  endtask

  task automatic send(input int n, input logic [31:0] v);
    for (int i = n - 1; i >= 0; i--) clk_bit(v[i]);
  endtask

  task automatic cs_low();
    @(negedge clk) cs = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic frame(input logic [1:0] op, input logic [AW-1:0] a,
                       input bit has_data, input logic [DW-1:0] d);
    @(negedge clk) cs = 1'b1;
    send(1, 1);
    send(2, op);
    send(AW, a);
    if (has_data) send(DW, d);
    cs_low();
  endtask

  // raise select, optionally expect busy, wait for ready, return cycles waited
  task automatic poll(input bit expect_busy, input string tag, output int waited);
    @(negedge clk) cs = 1'b1;
    repeat (2) @(negedge clk);
    check(do_oe === 1'b1, "R8 oe with cs high", do_oe, 1);
    check(do_o === !expect_busy, tag, do_o, !expect_busy);
    waited = 0;
    while (do_o !== 1'b1 && waited < 4 * BUSY) begin
      @(negedge clk);
      waited++;
    end
    check(do_o === 1'b1, "R8 ready reached", do_o, 1);
    cs_low();
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    logic [DW-1:0] got;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk) cs = 1'b1;
    send(1, 1);
    send(2, 2'b10);
    send(AW, a);
    got[DW-1] = do_o;
    for (int i = DW - 2; i >= 0; i--) begin
      clk_bit(1'b0);
      got[i] = do_o;
    end
    cs_low();
    act_q.push_back(got);
  endtask

  // monitor: compare each word the design shifted out against the expectation
  initial begin
    forever begin
      wait (act_q.size() > 0);
      begin
        logic [DW-1:0] a, e;
        string t;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(a === e, t, a, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int w;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(do_oe === 1'b0, "R8 reset oe low", do_oe, 0);
    @(negedge clk) cs = 1'b1;
    repeat (2) @(negedge clk);
    check(do_o === 1'b1, "R8 reset ready", do_o, 1);
    cs_low();

    do_read(4'd3, 8'hFF, "R1 reset contents");

    frame(2'b01, 4'd3, 1'b1, 8'h5A);
    poll(1'b0, "R2 no busy while locked", w);
    do_read(4'd3, 8'hFF, "R2 write ignored while locked");

    // R11: leading zeros before the enable frame
    @(negedge clk) cs = 1'b1;
    send(3, 3'b000);
    send(1, 1);
    send(2, 2'b00);
    send(AW, 4'b1100);
    cs_low();

    frame(2'b01, 4'd3, 1'b1, 8'h5A);
    poll(1'b1, "R8 busy after write", w);
    check(w > BUSY - 30 && w <= BUSY, "R8 busy length", w, BUSY);
    do_read(4'd3, 8'h5A, "R3 write stored (R11 enable seen)");

    frame(2'b01, 4'd9, 1'b1, 8'hC3);
    poll(1'b1, "R8 busy write 9", w);
    do_read(4'd9, 8'hC3, "R3 write addr 9");
    frame(2'b11, 4'd9, 1'b0, 8'h00);
    poll(1'b1, "R8 busy erase", w);
    do_read(4'd9, 8'hFF, "R4 erase to ones");
    do_read(4'd3, 8'h5A, "R4 neighbour kept");

    // R9: second frame during busy
    frame(2'b01, 4'd7, 1'b1, 8'h11);
    frame(2'b01, 4'd8, 1'b1, 8'h22);
    poll(1'b1, "R9 still busy", w);
    do_read(4'd7, 8'h11, "R9 first write done");
    do_read(4'd8, 8'hFF, "R9 write while busy ignored");

    // R7: one extra sk rise before cs drops
    @(negedge clk) cs = 1'b1;
    send(1, 1); send(2, 2'b01); send(AW, 4'd8); send(DW, 8'h33);
    clk_bit(1'b0);
    cs_low();
    poll(1'b0, "R7 late drop no busy", w);
    do_read(4'd8, 8'hFF, "R7 late drop discarded");

    // R7: cs drops before last data bit
    @(negedge clk) cs = 1'b1;
    send(1, 1); send(2, 2'b01); send(AW, 4'd8); send(DW - 1, 7'h55);
    cs_low();
    poll(1'b0, "R7 early drop no busy", w);
    do_read(4'd8, 8'hFF, "R7 early drop discarded");

    frame(2'b00, 4'b0100, 1'b1, 8'hA5);
    poll(1'b1, "R8 busy write-all", w);
    do_read(4'd0, 8'hA5, "R5 write-all low");
    do_read(4'd15, 8'hA5, "R5 write-all high");

    frame(2'b00, 4'b1000, 1'b0, 8'h00);
    poll(1'b1, "R8 busy erase-all", w);
    do_read(4'd0, 8'hFF, "R6 erase-all low");
    do_read(4'd15, 8'hFF, "R6 erase-all high");

    frame(2'b01, 4'd2, 1'b1, 8'h77);
    poll(1'b1, "R8 busy write 2", w);
    frame(2'b00, 4'b0000, 1'b0, 8'h00);
    frame(2'b11, 4'd2, 1'b0, 8'h00);
    poll(1'b0, "R10 erase locked no busy", w);
    do_read(4'd2, 8'h77, "R10 erase ignored, R1 read while locked");
    frame(2'b00, 4'b1000, 1'b0, 8'h00);
    poll(1'b0, "R10 erase-all locked no busy", w);
    do_read(4'd2, 8'h77, "R10 erase-all ignored");

    repeat (4) @(negedge clk);
    wait (act_q.size() == 0);
    #1;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule